// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two 8-bit buses, A and B, and carries data across in either direction through a storage stage. Each direction has its own storage element and its own three active-low controls: a chip enable, a latch enable and an output enable. The A-to-B storage takes its data from bus A and can drive bus B. The B-to-A storage takes its data from bus B and can drive bus A. The data path does not invert.

Each bus side is split into an input value, an output value and one drive-enable bit, so the block synthesizes without internal tri-states. A pad ring or wrapper turns a drive-enable bit and its output value into a real tri-state bus. Storage is sampled on the clock. While a direction is transparent, its output follows the live source bus with no clock delay. A contention flag shows when both directions drive at once, which would make the shared pins act as both inputs and outputs. The flag does not change the block's behaviour.

Top module: `latched_xcvr`

## Requirements
- R1: While `rstN` is low, both storage registers are cleared to 8'h00. The first held value seen after reset is therefore zero.
- R2: When a direction's chip enable and latch enable are both low (transparent), its output value equals the live source bus in the same cycle (`bOut == aIn`, `aOut == bIn`).
- R3: At each clock edge that finds a direction transparent, the storage loads the source value. After the latch enable goes high, later changes on the source bus do not reach the output.
- R4: While latch enable is high, the output value shows the stored value and stays unchanged across clock edges, whatever the source bus, chip enable or output enable do.
- R5: While chip enable is high, the storage holds its value and that direction's drive-enable is 0, whatever latch enable and output enable do.
- R6: A direction's drive-enable (`bDrive` for A-to-B, `aDrive` for B-to-A) is 1 exactly when its chip enable and output enable are both low. Output enable high on its own forces 0.
- R7: The path is non-inverting. When not transparent, the output value is the stored bits unchanged, not the live source.
- R8: `contention` is 1 exactly when `aDrive` and `bDrive` are both 1.
- R9: The two directions are independent. No control or data on one direction changes the storage, output value or drive-enable of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Storage sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| aIn | input | 8 | Value seen on bus A |
| bIn | input | 8 | Value seen on bus B |
| ceAbN | input | 1 | A-to-B chip enable, active low |
| leAbN | input | 1 | A-to-B latch enable, active low |
| oeAbN | input | 1 | A-to-B output enable, active low |
| ceBaN | input | 1 | B-to-A chip enable, active low |
| leBaN | input | 1 | B-to-A latch enable, active low |
| oeBaN | input | 1 | B-to-A output enable, active low |
| aOut | output | 8 | Value to place on bus A |
| aDrive | output | 1 | Drive-enable for bus A |
| bOut | output | 8 | Value to place on bus B |
| bDrive | output | 1 | Drive-enable for bus B |
| contention | output | 1 | Both directions driving at once |

## Verification
The hardest case to reach is a stored value that must survive source changes after capture, while the other direction is exercised at the same time. The bench covers it with a sweep over all 64 combinations of the two directions' three-bit control codes. Each combination runs with several data patterns and a different source value before every clock edge. A bench model of both storages is updated only on edges where the direction is transparent. Any stale or wrongly refreshed value then shows at the output during a later held phase.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int NUM_DIRS = 2;
  localparam int DIR_AB = 0;
  localparam int DIR_BA = 1;

  // Per-direction strobes sent from control to datapath
  typedef struct packed {
    logic pass;   // storage transparent: load each edge, show live source
    logic drive;  // destination bus driven
  } dirStrobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic [NUM_DIRS-1:0] ceN,
  input  logic [NUM_DIRS-1:0] leN,
  input  logic [NUM_DIRS-1:0] oeN,
  output dirStrobe_t          strobes [NUM_DIRS]
);
  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    always_comb begin
      strobes[d].pass  = !ceN[d] && !leN[d];
      strobes[d].drive = !ceN[d] && !oeN[d];
    end
  end
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dirStrobe_t       strobe,
  input  logic [WIDTH-1:0] srcIn,
  output logic [WIDTH-1:0] dstOut,
  output logic             dstDrive
);
  logic [WIDTH-1:0] held;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            held <= '0;
    else if (strobe.pass) held <= srcIn;
  end

  // Transparent: live source; otherwise the held word
  assign dstOut   = strobe.pass ? srcIn : held;
  assign dstDrive = strobe.drive;
endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             ceAbN,
  input  logic             leAbN,
  input  logic             oeAbN,
  input  logic             ceBaN,
  input  logic             leBaN,
  input  logic             oeBaN,
  output logic [WIDTH-1:0] aOut,
  output logic             aDrive,
  output logic [WIDTH-1:0] bOut,
  output logic             bDrive,
  output logic             contention
);
  dirStrobe_t strobes [NUM_DIRS];

  logic [NUM_DIRS-1:0] ceVec, leVec, oeVec;
  logic [WIDTH-1:0]    srcVec [NUM_DIRS];
  logic [WIDTH-1:0]    dstVec [NUM_DIRS];
  logic [NUM_DIRS-1:0] drvVec;

  assign ceVec = {ceBaN, ceAbN};
  assign leVec = {leBaN, leAbN};
  assign oeVec = {oeBaN, oeAbN};
  assign srcVec[DIR_AB] = aIn;
  assign srcVec[DIR_BA] = bIn;

  xcvr_ctrl u_ctrl (
    .ceN     (ceVec),
    .leN     (leVec),
    .oeN     (oeVec),
    .strobes (strobes)
  );

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_path
    xcvr_store #(.WIDTH(WIDTH)) u_store (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (strobes[d]),
      .srcIn    (srcVec[d]),
      .dstOut   (dstVec[d]),
      .dstDrive (drvVec[d])
    );
  end

  assign bOut       = dstVec[DIR_AB];
  assign bDrive     = drvVec[DIR_AB];
  assign aOut       = dstVec[DIR_BA];
  assign aDrive     = drvVec[DIR_BA];
  assign contention = &drvVec;
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] bIn,
  input logic             ceAbN,
  input logic             leAbN,
  input logic             oeAbN,
  input logic             ceBaN,
  input logic             leBaN,
  input logic             oeBaN,
  input logic [WIDTH-1:0] aOut,
  input logic             aDrive,
  input logic [WIDTH-1:0] bOut,
  input logic             bDrive,
  input logic             contention
);
  // R2: transparent output follows live source
  p_transp_ab_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ceAbN && !leAbN) |-> (bOut == aIn));
  p_transp_ba_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ceBaN && !leBaN) |-> (aOut == bIn));

  // R4/R5: not transparent for two sampled cycles -> output stable
  p_hold_ab_r4: assert property (@(posedge clk) disable iff (!rstN)
    (($past(ceAbN) || $past(leAbN)) && (ceAbN || leAbN)) |-> $stable(bOut));
  p_hold_ba_r4: assert property (@(posedge clk) disable iff (!rstN)
    (($past(ceBaN) || $past(leBaN)) && (ceBaN || leBaN)) |-> $stable(aOut));

  // R5: chip enable high floats the destination
  p_cefloat_ab_r5: assert property (@(posedge clk) disable iff (!rstN)
    ceAbN |-> !bDrive);
  p_cefloat_ba_r5: assert property (@(posedge clk) disable iff (!rstN)
    ceBaN |-> !aDrive);

  // R6: output enable high alone floats the destination
  p_oefloat_ab_r6: assert property (@(posedge clk) disable iff (!rstN)
    oeAbN |-> !bDrive);
  p_oefloat_ba_r6: assert property (@(posedge clk) disable iff (!rstN)
    oeBaN |-> !aDrive);

  // R8: both driving is always flagged
  p_contend_r8: assert property (@(posedge clk) disable iff (!rstN)
    (aDrive && bDrive) |-> contention);
  p_nocontend_r8: assert property (@(posedge clk) disable iff (!rstN)
    contention |-> (!ceAbN && !ceBaN));
endmodule

bind latched_xcvr xcvr_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_latched_xcvr.sv
`timescale 1ns/1ps
module sim_latched_xcvr;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] aIn = '0, bIn = '0;
  logic       ceAbN = 1'b1, leAbN = 1'b1, oeAbN = 1'b1;
  logic       ceBaN = 1'b1, leBaN = 1'b1, oeBaN = 1'b1;
  logic [7:0] aOut, bOut;
  logic       aDrive, bDrive, contention;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] mAb = '0, mBa = '0;  // bench model of stored words
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  latched_xcvr u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Apply controls {ce,le,oe} and data just after a falling edge, check, then clock
  task automatic step(input logic [2:0] ab, input logic [2:0] ba,
                      input logic [7:0] a, input logic [7:0] b);
    logic tAb, tBa, dAb, dBa;
    @(negedge clk);
    {ceAbN, leAbN, oeAbN} = ab;
    {ceBaN, leBaN, oeBaN} = ba;
    aIn = a; bIn = b;
    #(CLK_PERIOD/4);
    tAb = !ab[2] && !ab[1];
    tBa = !ba[2] && !ba[1];
    dAb = !ab[2] && !ab[0];
    dBa = !ba[2] && !ba[0];
    chk(tAb ? "R2 bOut transparent" : "R4/R7 bOut held", bOut, tAb ? a : mAb);
    chk(tBa ? "R2 aOut transparent" : "R4/R7 aOut held", aOut, tBa ? b : mBa);
    chk("R5/R6 bDrive", {7'b0, bDrive}, {7'b0, dAb});
    chk("R5/R6 aDrive", {7'b0, aDrive}, {7'b0, dBa});
    chk("R8 contention", {7'b0, contention}, {7'b0, dAb && dBa});
    @(posedge clk);
    if (tAb) mAb = a;  // R3 load on transparent edge
    if (tBa) mBa = b;
  endtask

  initial begin
    // R1: reset state
    {ceAbN, leAbN, oeAbN} = 3'b010;
    {ceBaN, leBaN, oeBaN} = 3'b010;
    aIn = 8'hFF; bIn = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 bOut reset", bOut, 8'h00);
    chk("R1 aOut reset", aOut, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    step(3'b010, 3'b010, 8'h3C, 8'hC3);  // held zero survives new inputs (R1)

    // R3: capture then ignore later input changes (A-to-B), B-to-A frozen (R9)
    step(3'b001, 3'b110, 8'h5A, 8'h11);
    step(3'b001, 3'b110, 8'h96, 8'h22);
    step(3'b011, 3'b110, 8'h0F, 8'h33);
    chk("R3 captured A-to-B", mAb, 8'h96);
    step(3'b010, 3'b110, 8'hF0, 8'h44);
    step(3'b010, 3'b110, 8'h01, 8'h55);
    chk("R3 bOut after input change", bOut, 8'h96);

    // R3/R9: capture on B-to-A while A-to-B holds
    step(3'b010, 3'b000, 8'h77, 8'hE1);
    step(3'b010, 3'b010, 8'h88, 8'h1E);
    chk("R9 aOut captured", aOut, 8'hE1);
    chk("R9 bOut untouched", bOut, 8'h96);

    // R5: ce high with le low does not load
    step(3'b100, 3'b110, 8'hAA, 8'h99);
    step(3'b011, 3'b010, 8'h55, 8'h66);
    chk("R5 bOut not loaded while ce high", bOut, 8'h96);

    // Sweep of all control pairs with several data patterns
    for (int k = 0; k < 4; k++) begin
      for (int ab = 0; ab < 8; ab++) begin
        for (int ba = 0; ba < 8; ba++) begin
          step(ab[2:0], ba[2:0], 8'(ab * 37 + ba * 11 + k * 71 + 8'h5A),
               8'(~(ab * 13 + ba * 29 + k * 53)));
        end
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule